// File: doc/BRIEF.md
# Streaming Fletcher Checksum Engine

This block computes a two-byte Fletcher checksum over a byte stream, taking one byte per clock through a valid/ready input. Each byte carries a start-of-block flag and an end-of-block flag. Two running values are kept, both modulo 2^W-1. The first adds each byte. The second adds the updated first value. Both are computed as W-bit additions whose carry-out is fed back into the sum, so an accumulator may hold the all-ones pattern as an alternative form of zero. That pattern is normalized before any result is formed from it.

The operating mode is sampled with the first byte of each block. In generate mode the block closes by holding input ready low while it presents two check bytes, in order, on a separate valid/ready output. The check bytes are chosen so that a receiver that runs the same checksum over the data and both check bytes ends with both sums at zero. In verify mode the stream already ends with its two check bytes. One cycle after the end-of-block byte is taken, a done pulse appears, and ok is high with it when both final sums are congruent to zero.

Top module: `fletcher_engine`

## Requirements
- R1: A synchronous active-low reset clears both sums and returns the control to data intake: in_ready=1, chk_valid=0, done=0, ok=0.
- R2: A byte accepted with in_sob=1 starts both sums from zero, whatever an earlier block (finished or abandoned) left behind.
- R3: For every accepted byte b, sum1 becomes (sum1+b) mod 255 first, and then sum2 becomes (sum2+new sum1) mod 255.
- R4: In generate mode the first check byte equals 255 - ((sum1+sum2) mod 255), formed from the sums after the end-of-block byte.
- R5: The second check byte equals 255 - ((sum1+first check byte) mod 255). The first check byte is presented in the first cycle after the end-of-block byte is accepted, and the second follows it.
- R6: While check bytes are pending, in_ready is 0, chk_valid is 1, and chk_data stays unchanged until chk_ready accepts it.
- R7: After the second check byte is accepted, chk_valid drops and in_ready returns to 1 in the next cycle.
- R8: In verify mode, done pulses for one cycle, one cycle after the end-of-block byte is accepted. ok is 1 in that cycle exactly when both final sums are 0 mod 255, and ok is 0 whenever done is 0.
- R9: An accumulator value of 255 is treated as zero. A block consisting of the single byte 255 yields check bytes 255, 255, and verifying the three bytes 255, 255, 255 gives ok=1.
- R10: Cycles with in_valid=0 leave the sums unchanged, so idle gaps inside a block do not alter the check bytes.
- R11: mode_verify (1=verify, 0=generate) is sampled only on the start-of-block byte. Changing it later in the block has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_verify | input | 1 | Mode for the block being started: 1 verify, 0 generate |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts a byte |
| in_data | input | W | Input byte |
| in_sob | input | 1 | Byte is the first of a block |
| in_eob | input | 1 | Byte is the last of a block |
| chk_valid | output | 1 | Check byte presented |
| chk_ready | input | 1 | Downstream takes the check byte |
| chk_data | output | W | Check byte (first, then second) |
| done | output | 1 | Verify result pulse |
| ok | output | 1 | Verify passed, qualified by done |

## Verification
The bench builds the engine with the default width W=8, so the modulus is 255 and the check bytes can be predicted with ordinary integer arithmetic. At that width a single data byte of 255 leaves both accumulators holding the all-ones pattern without any carry-out. This exercises the alternate-zero path in both the check-byte formulas and the pass test. A 100-byte block drives many carry wrap-arounds, and stalled chk_ready, idle input gaps and mid-block mode flips are all reachable at this width.

// File: rtl/fl_pkg.sv
// Shared types for the Fletcher checksum engine.
package fl_pkg;
    // Control phases: taking data, presenting check byte one, check byte two.
    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_CHK1 = 2'd1,
        ST_CHK2 = 2'd2
    } fl_state_e;
endpackage

// File: rtl/fl_ocadd.sv
// Ones'-complement adder: W-bit sum with the carry-out folded back in.
// Assumes: result is congruent to a+b modulo 2^W-1; all-ones may stand for zero.
module fl_ocadd #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] raw;

    // Wide add, then fold carry into the low bits (cannot overflow again).
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/fl_accum.sv
// Running sum pair. On each enabled byte, sum1 takes the byte first, then
// sum2 takes the new sum1. A clear restarts both lanes from zero.
// Assumes: en and clr come from the same accepted byte.
module fl_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum1,
    output logic [W-1:0] sum2,
    output logic [W-1:0] nxt1,
    output logic [W-1:0] nxt2
);
    logic [W-1:0] base1;
    logic [W-1:0] base2;

    // Pick the starting point: zero on start-of-block, else the held sums.
    always_comb begin
        base1 = clr ? '0 : sum1;
        base2 = clr ? '0 : sum2;
    end

    fl_ocadd #(.W(W)) u_add1 (.a(base1), .b(din),  .y(nxt1));
    fl_ocadd #(.W(W)) u_add2 (.a(base2), .b(nxt1), .y(nxt2));

    // Register the sums on accepted bytes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum1 <= '0;
            sum2 <= '0;
        end else if (en) begin
            sum1 <= nxt1;
            sum2 <= nxt2;
        end
    end

    AST_SUMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sum1) && $stable(sum2)))
        else $error("sums moved without a byte"); // R10
endmodule

// File: rtl/fl_checkgen.sv
// Forms the two trailing check bytes from the data-only sums.
// Assumes: sums may hold all-ones as zero; they are normalized first.
module fl_checkgen #(
    parameter int W = 8
) (
    input  logic [W-1:0] sum1,
    input  logic [W-1:0] sum2,
    output logic [W-1:0] chk1,
    output logic [W-1:0] chk2
);
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] n1, n2, t1, t2, nt1, nt2;

    // Normalize stored sums: all-ones is the alternate zero.
    always_comb begin
        n1 = (sum1 == ONES) ? '0 : sum1;
        n2 = (sum2 == ONES) ? '0 : sum2;
    end

    fl_ocadd #(.W(W)) u_t1 (.a(n1), .b(n2),   .y(t1));
    fl_ocadd #(.W(W)) u_t2 (.a(n1), .b(chk1), .y(t2));

    // Modulus minus normalized residue equals its bitwise complement.
    always_comb begin
        nt1  = (t1 == ONES) ? '0 : t1;
        chk1 = ~nt1;
        nt2  = (t2 == ONES) ? '0 : t2;
        chk2 = ~nt2;
    end
endmodule

// File: rtl/fl_ctrl.sv
// Block sequencing: mode latch, check-byte phases, verify result pulse.
// Assumes: the next-sum inputs reflect the byte being accepted this cycle.
module fl_ctrl
    import fl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_verify,
    input  logic         in_valid,
    input  logic         in_sob,
    input  logic         in_eob,
    input  logic         chk_ready,
    input  logic [W-1:0] nxt1,
    input  logic [W-1:0] nxt2,
    output logic         in_ready,
    output logic         accept,
    output logic         chk_valid,
    output logic         sel_second,
    output logic         done,
    output logic         ok
);
    localparam logic [W-1:0] ONES = '1;

    fl_state_e state_q, state_d;
    logic      mode_q, mode_eff, last_hit, sums_zero;

    // Handshake, effective mode for this byte, and the zero test.
    always_comb begin
        in_ready   = (state_q == ST_DATA);
        accept     = in_valid && in_ready;
        chk_valid  = (state_q != ST_DATA);
        sel_second = (state_q == ST_CHK2);
        mode_eff   = (accept && in_sob) ? mode_verify : mode_q;
        last_hit   = accept && in_eob;
        sums_zero  = ((nxt1 == '0) || (nxt1 == ONES)) &&
                     ((nxt2 == '0) || (nxt2 == ONES));
    end

    // Next phase of the block sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_DATA: if (last_hit && !mode_eff) state_d = ST_CHK1;
            ST_CHK1: if (chk_ready)             state_d = ST_CHK2;
            ST_CHK2: if (chk_ready)             state_d = ST_DATA;
            default:                            state_d = ST_DATA;
        endcase
    end

    // Phase register and mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DATA;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && in_sob) mode_q <= mode_verify;
        end
    end

    // Verify result, one cycle after the closing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ok   <= 1'b0;
        end else begin
            done <= last_hit && mode_eff;
            ok   <= last_hit && mode_eff && sums_zero;
        end
    end

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> done)
        else $error("ok without done"); // R8
    AST_DONE_AFTER_EOB: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready && in_eob))
        else $error("done without closing byte"); // R8
    AST_CHK_STARTS_AT_EOB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_valid) |-> $past(in_valid && in_ready && in_eob))
        else $error("check bytes without closing byte"); // R5
    AST_BUSY_MEANS_CHK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> chk_valid)
        else $error("input stalled with no check byte"); // R6
    AST_RETURN_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready && sel_second) |=> (in_ready && !chk_valid))
        else $error("no return after second check byte"); // R7
endmodule

// File: rtl/fletcher_engine.sv
// Streaming Fletcher checksum engine, one byte per clock.
// Generate mode appends two check bytes; verify mode reports pass/fail.
// Assumes: upstream marks block edges with in_sob / in_eob.
module fletcher_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_verify,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_sob,
    input  logic         in_eob,
    output logic         chk_valid,
    input  logic         chk_ready,
    output logic [W-1:0] chk_data,
    output logic         done,
    output logic         ok
);
    logic         accept, sel_second;
    logic [W-1:0] sum1, sum2, nxt1, nxt2, chk1, chk2;

    fl_accum #(.W(W)) u_accum (
        .clk(clk), .rst_n(rst_n), .en(accept), .clr(in_sob), .din(in_data),
        .sum1(sum1), .sum2(sum2), .nxt1(nxt1), .nxt2(nxt2)
    );

    fl_checkgen #(.W(W)) u_checkgen (
        .sum1(sum1), .sum2(sum2), .chk1(chk1), .chk2(chk2)
    );

    fl_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_verify(mode_verify),
        .in_valid(in_valid), .in_sob(in_sob), .in_eob(in_eob),
        .chk_ready(chk_ready), .nxt1(nxt1), .nxt2(nxt2),
        .in_ready(in_ready), .accept(accept), .chk_valid(chk_valid),
        .sel_second(sel_second), .done(done), .ok(ok)
    );

    // Present whichever check byte the sequence is on.
    always_comb chk_data = sel_second ? chk2 : chk1;

    AST_CHK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_data)))
        else $error("check byte changed under backpressure"); // R6
endmodule

// File: tb/fletcher_engine_tb.sv
module fletcher_engine_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, mode_verify, in_valid, in_sob, in_eob, chk_ready;
    logic [W-1:0] in_data;
    logic         in_ready, chk_valid, done, ok;
    logic [W-1:0] chk_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [7:0] mem [0:127];
    int  exp_c1, exp_c2;

    always #4 clk = ~clk;

    fletcher_engine #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_verify(mode_verify),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sob(in_sob), .in_eob(in_eob), .chk_valid(chk_valid),
        .chk_ready(chk_ready), .chk_data(chk_data), .done(done), .ok(ok)
    );

    task automatic check(input bit good, input string req, input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference sums over mem[0:n-1], plain modulo arithmetic.
    task automatic model(input int n, output int s1, output int s2);
        s1 = 0; s2 = 0;
        for (int i = 0; i < n; i++) begin
            s1 = (s1 + mem[i]) % 255;
            s2 = (s2 + s1) % 255;
        end
    endtask

    // Drive mem[0:n-1]; gap idle cycles before odd bytes; flip toggles mode after byte 0.
    task automatic drive(input int n, input bit vmode, input int gap, input bit flip, input bit close);
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % 2 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end else begin
                @(negedge clk);
            end
            in_valid    = 1'b1;
            in_data     = mem[i];
            in_sob      = (i == 0);
            in_eob      = close && (i == n - 1);
            mode_verify = (flip && i > 0) ? ~vmode : vmode;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0;
    endtask

    // Generate a block, check both check bytes, append them to mem.
    task automatic run_gen(input int n, input int stall, input int gap, input bit flip, input string tag);
        int s1, s2;
        model(n, s1, s2);
        exp_c1 = 255 - ((s1 + s2) % 255);
        exp_c2 = 255 - ((s1 + exp_c1) % 255);
        drive(n, 1'b0, gap, flip, 1'b1);
        check(chk_valid === 1'b1, {"R5 chk_valid ", tag}, chk_valid, 1);
        check(in_ready === 1'b0, {"R6 in_ready ", tag}, in_ready, 0);
        check(chk_data === exp_c1[7:0], {"R4 first check ", tag}, chk_data, exp_c1);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check(chk_valid === 1'b1 && chk_data === exp_c1[7:0],
                  {"R6 hold ", tag}, chk_data, exp_c1);
        end
        chk_ready = 1'b1;
        @(negedge clk);
        check(chk_data === exp_c2[7:0], {"R5 second check ", tag}, chk_data, exp_c2);
        check(in_ready === 1'b0, {"R6 busy ", tag}, in_ready, 0);
        @(negedge clk);
        chk_ready = 1'b0;
        check(in_ready === 1'b1 && chk_valid === 1'b0, {"R7 return ", tag}, in_ready, 1);
        mem[n]     = exp_c1[7:0];
        mem[n + 1] = exp_c2[7:0];
    endtask

    // Verify mem[0:n-1]; expected ok from the model.
    task automatic run_ver(input int n, input string tag);
        int s1, s2;
        bit exp_ok;
        model(n, s1, s2);
        exp_ok = (s1 == 0) && (s2 == 0);
        drive(n, 1'b1, 0, 1'b0, 1'b1);
        check(done === 1'b1, {"R8 done ", tag}, done, 1);
        check(ok === exp_ok, {"R8 ok ", tag}, ok, exp_ok);
        @(negedge clk);
        check(done === 1'b0 && ok === 1'b0, {"R8 pulse end ", tag}, done, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0;
        chk_ready = 1'b0; mode_verify = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1 && chk_valid === 1'b0, "R1 ready/valid", in_ready, 1);
        check(done === 1'b0 && ok === 1'b0, "R1 done/ok", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic;
        mem[0] = 8'd1; mem[1] = 8'd2; mem[2] = 8'd3;
        run_gen(3, 0, 0, 1'b0, "R3 short");
        run_ver(5, "short good");
        mem[1] = mem[1] ^ 8'h10;
        run_ver(5, "short corrupt");
    endtask

    task automatic t_long_stall;
        for (int i = 0; i < 100; i++) mem[i] = 8'((i * 37 + 5) % 256);
        run_gen(100, 3, 0, 1'b0, "R3 long stall");
        run_ver(102, "long good");
    endtask

    task automatic t_alt_zero;
        mem[0] = 8'hFF;
        run_gen(1, 0, 0, 1'b0, "R9 single ff");
        check(mem[1] == 8'hFF && mem[2] == 8'hFF, "R9 ff pair", mem[1], 255);
        run_ver(3, "R9 ff triple");
    endtask

    task automatic t_gaps_and_flip;
        for (int i = 0; i < 9; i++) mem[i] = 8'(200 + i * 7);
        run_gen(9, 1, 2, 1'b0, "R10 gaps");
        run_gen(9, 0, 0, 1'b1, "R11 flip");
    endtask

    task automatic t_restart;
        for (int i = 0; i < 6; i++) mem[i] = 8'(90 + i);
        drive(6, 1'b1, 0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) mem[i] = 8'(17 * i + 3);
        run_gen(4, 0, 0, 1'b0, "R2 restart");
        run_ver(6, "R2 restart good");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_long_stall();
        t_alt_zero();
        t_gaps_and_flip();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule